// File: doc/BRIEF.md
# Carry-Flag Add/Subtract Unit

This block is a 32-bit integer adder/subtractor that keeps one carry flag between operations, so that wider values held as pairs of 32-bit words can be added or subtracted one word at a time. A carrying operation on the low words writes the flag. An extended operation on the high words then adds the stored flag back in and writes the flag again.

Four operations share one adder. The carrying add and the extended add sum their operands. The carrying subtract takes the second operand from the first. The extended subtract-from adds the second operand to the inverted first operand. In both subtract forms the flag means "no borrow". In the extended forms a select input can replace the first operand with a literal zero, which is how a high word receives just the carry. The flag is also shown at a fixed position inside a status word.

Top module: `carry_addsub`

## Requirements
- R1: While `rstN` is low, `result`, `carryFlag` and `statusWord` are all zero.
- R2: Operation code 2'b00 (carrying add) gives `result` = A+B mod 2^32, and `carryFlag` = 1 exactly when the true sum exceeds 0xFFFFFFFF.
- R3: Operation code 2'b01 (extended add) gives `result` = A+B+CA mod 2^32, where CA is the flag before the operation. `carryFlag` is the carry out of that 33-bit sum.
- R4: Operation code 2'b10 (carrying subtract) gives `result` = A-B mod 2^32. `carryFlag` is 1 when A >= B unsigned (no borrow) and 0 when a borrow occurs.
- R5: Operation code 2'b11 (extended subtract-from) gives `result` = (~A)+B+CA mod 2^32. `carryFlag` is the carry out of that 33-bit sum.
- R6: In the extended forms (2'b01, 2'b11), `srcAIsZero` = 1 makes A a literal zero. In the carrying forms (2'b00, 2'b10) it has no effect on `result` or `carryFlag`.
- R7: `statusWord` bit 2 always equals `carryFlag`, and every other bit of `statusWord` is zero.
- R8: While `opValid` is low, `result` and `carryFlag` keep their values, whatever the other inputs do.
- R9: An operation is taken on the rising edge where `opValid` is high, and its result and flag appear after that edge. An extended operation issued on the very next cycle uses the flag written by the previous operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| opValid | input | 1 | Take the operation on this edge |
| opSel | input | 2 | Operation code (see R2 to R5) |
| srcA | input | 32 | First operand |
| srcB | input | 32 | Second operand |
| srcAIsZero | input | 1 | First source is register zero (extended forms use literal zero) |
| result | output | 32 | Registered result word |
| carryFlag | output | 1 | Stored carry flag |
| statusWord | output | 32 | Exception/status word with the carry flag at bit 2 |

## Verification
The result word and the carry flag are registered together. Both are due in the cycle after the rising edge that sees `opValid` high, so the bench drives each operation on a falling edge and samples shortly after the next rising edge. The status word follows the flag register with no extra delay and is checked at the same sample point. Extended operations are issued back to back with the carrying ones, so the flag each one consumes is the one produced a single cycle earlier. The bench model carries its own copy of the flag forward in the same way.

// File: rtl/carry_addsub_pkg.sv
`timescale 1ns/1ps
package carry_addsub_pkg;

  typedef enum logic [1:0] {
    OP_ADD_CARRY  = 2'b00,
    OP_ADD_EXT    = 2'b01,
    OP_SUB_CARRY  = 2'b10,
    OP_SUBF_EXT   = 2'b11
  } opCode_e;

  typedef enum logic [1:0] {
    CIN_ZERO = 2'b00,
    CIN_ONE  = 2'b01,
    CIN_FLAG = 2'b10
  } carryIn_e;

  // Strobes from control to datapath.
  typedef struct packed {
    logic     load;
    logic     zeroA;
    logic     invA;
    logic     invB;
    carryIn_e cinSel;
  } strobes_t;

endpackage

// File: rtl/carry_addsub_ctrl.sv
`timescale 1ns/1ps
module carry_addsub_ctrl
  import carry_addsub_pkg::*;
(
  input  logic       opValid,
  input  logic [1:0] opSel,
  input  logic       srcAIsZero,
  output strobes_t   strobes
);

  opCode_e opCode;
  assign opCode = opCode_e'(opSel);

  always_comb begin
    strobes        = '0;
    strobes.load   = opValid;
    strobes.cinSel = CIN_ZERO;
    unique case (opCode)
      OP_ADD_CARRY: begin
        strobes.cinSel = CIN_ZERO;
      end
      OP_ADD_EXT: begin
        strobes.zeroA  = srcAIsZero;
        strobes.cinSel = CIN_FLAG;
      end
      OP_SUB_CARRY: begin
        // A - B is formed as A + ~B + 1
        strobes.invB   = 1'b1;
        strobes.cinSel = CIN_ONE;
      end
      OP_SUBF_EXT: begin
        strobes.zeroA  = srcAIsZero;
        strobes.invA   = 1'b1;
        strobes.cinSel = CIN_FLAG;
      end
      default: strobes.cinSel = CIN_ZERO;
    endcase
  end

endmodule

// File: rtl/carry_addsub_adder.sv
`timescale 1ns/1ps
module carry_addsub_adder #(
  parameter int WIDTH  = 32,
  parameter bit RIPPLE = 1'b0
) (
  input  logic [WIDTH-1:0] addA,
  input  logic [WIDTH-1:0] addB,
  input  logic             carryIn,
  output logic [WIDTH-1:0] sum,
  output logic             carryOut
);

  generate
    if (RIPPLE) begin : g_ripple
      logic [WIDTH:0] chain;
      assign chain[0] = carryIn;
      for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        assign sum[i]     = addA[i] ^ addB[i] ^ chain[i];
        assign chain[i+1] = (addA[i] & addB[i]) | (chain[i] & (addA[i] ^ addB[i]));
      end
      assign carryOut = chain[WIDTH];
    end else begin : g_infer
      logic [WIDTH:0] wide;
      assign wide     = {1'b0, addA} + {1'b0, addB} + {{WIDTH{1'b0}}, carryIn};
      assign sum      = wide[WIDTH-1:0];
      assign carryOut = wide[WIDTH];
    end
  endgenerate

endmodule

// File: rtl/carry_addsub_dp.sv
`timescale 1ns/1ps
module carry_addsub_dp
  import carry_addsub_pkg::*;
#(
  parameter int WIDTH        = 32,
  parameter int STATUS_WIDTH = 32,
  parameter int CARRY_BIT    = 2,
  parameter bit RIPPLE       = 1'b0
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  strobes_t                strobes,
  input  logic [WIDTH-1:0]        srcA,
  input  logic [WIDTH-1:0]        srcB,
  output logic [WIDTH-1:0]        result,
  output logic                    carryFlag,
  output logic [STATUS_WIDTH-1:0] statusWord
);

  logic [WIDTH-1:0] gatedA;
  logic [WIDTH-1:0] opA;
  logic [WIDTH-1:0] opB;
  logic             cin;
  logic [WIDTH-1:0] sum;
  logic             cout;
  logic [WIDTH-1:0] resultReg;
  logic             carryReg;

  assign gatedA = strobes.zeroA ? '0 : srcA;
  assign opA    = strobes.invA ? ~gatedA : gatedA;
  assign opB    = strobes.invB ? ~srcB : srcB;

  always_comb begin
    unique case (strobes.cinSel)
      CIN_ONE:  cin = 1'b1;
      CIN_FLAG: cin = carryReg;
      default:  cin = 1'b0;
    endcase
  end

  carry_addsub_adder #(
    .WIDTH (WIDTH),
    .RIPPLE(RIPPLE)
  ) u_adder (
    .addA    (opA),
    .addB    (opB),
    .carryIn (cin),
    .sum     (sum),
    .carryOut(cout)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resultReg <= '0;
      carryReg  <= 1'b0;
    end else if (strobes.load) begin
      resultReg <= sum;
      carryReg  <= cout;
    end
  end

  assign result    = resultReg;
  assign carryFlag = carryReg;

  generate
    for (genvar s = 0; s < STATUS_WIDTH; s++) begin : g_status
      if (s == CARRY_BIT) begin : g_ca
        assign statusWord[s] = carryReg;
      end else begin : g_zero
        assign statusWord[s] = 1'b0;
      end
    end
  endgenerate

endmodule

// File: rtl/carry_addsub.sv
`timescale 1ns/1ps
module carry_addsub
  import carry_addsub_pkg::*;
#(
  parameter int WIDTH        = 32,
  parameter int STATUS_WIDTH = 32,
  parameter int CARRY_BIT    = 2,
  parameter bit RIPPLE       = 1'b0
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    opValid,
  input  logic [1:0]              opSel,
  input  logic [WIDTH-1:0]        srcA,
  input  logic [WIDTH-1:0]        srcB,
  input  logic                    srcAIsZero,
  output logic [WIDTH-1:0]        result,
  output logic                    carryFlag,
  output logic [STATUS_WIDTH-1:0] statusWord
);

  strobes_t strobes;

  carry_addsub_ctrl u_ctrl (
    .opValid   (opValid),
    .opSel     (opSel),
    .srcAIsZero(srcAIsZero),
    .strobes   (strobes)
  );

  carry_addsub_dp #(
    .WIDTH       (WIDTH),
    .STATUS_WIDTH(STATUS_WIDTH),
    .CARRY_BIT   (CARRY_BIT),
    .RIPPLE      (RIPPLE)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .srcA      (srcA),
    .srcB      (srcB),
    .result    (result),
    .carryFlag (carryFlag),
    .statusWord(statusWord)
  );

endmodule

// File: rtl/carry_addsub_chk.sv
`timescale 1ns/1ps
module carry_addsub_chk #(
  parameter int WIDTH        = 32,
  parameter int STATUS_WIDTH = 32,
  parameter int CARRY_BIT    = 2
) (
  input logic                    clk,
  input logic                    rstN,
  input logic                    opValid,
  input logic [1:0]              opSel,
  input logic [WIDTH-1:0]        srcA,
  input logic [WIDTH-1:0]        srcB,
  input logic                    srcAIsZero,
  input logic [WIDTH-1:0]        result,
  input logic                    carryFlag,
  input logic [STATUS_WIDTH-1:0] statusWord
);

  function automatic logic [WIDTH:0] widen(input logic [WIDTH-1:0] v);
    return {1'b0, v};
  endfunction

  function automatic logic [WIDTH:0] widenBit(input logic b);
    return {{WIDTH{1'b0}}, b};
  endfunction

  function automatic logic [WIDTH-1:0] pickA(input logic z, input logic [WIDTH-1:0] a);
    return z ? '0 : a;
  endfunction

  // R7: flag mirrored at its status position, all else zero
  a_r7_status_mirror: assert property (@(posedge clk) disable iff (!rstN)
    (statusWord[CARRY_BIT] == carryFlag) && ($countones(statusWord) == int'(carryFlag)));

  // R8: idle cycles hold state
  a_r8_idle_hold: assert property (@(posedge clk) disable iff (!rstN)
    !opValid |=> ($stable(result) && $stable(carryFlag)));

  // R2
  a_r2_add_carry: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opSel == 2'b00) |=>
      ({carryFlag, result} == widen($past(srcA)) + widen($past(srcB))));

  // R3, R6
  a_r3_add_ext: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opSel == 2'b01) |=>
      ({carryFlag, result} == widen(pickA($past(srcAIsZero), $past(srcA)))
                              + widen($past(srcB)) + widenBit($past(carryFlag))));

  // R4
  a_r4_sub_carry: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opSel == 2'b10) |=>
      ((result == $past(srcA) - $past(srcB)) && (carryFlag == ($past(srcA) >= $past(srcB)))));

  // R5, R6
  a_r5_subf_ext: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opSel == 2'b11) |=>
      ({carryFlag, result} == widen(~pickA($past(srcAIsZero), $past(srcA)))
                              + widen($past(srcB)) + widenBit($past(carryFlag))));

endmodule

bind carry_addsub carry_addsub_chk #(
  .WIDTH       (WIDTH),
  .STATUS_WIDTH(STATUS_WIDTH),
  .CARRY_BIT   (CARRY_BIT)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .opValid   (opValid),
  .opSel     (opSel),
  .srcA      (srcA),
  .srcB      (srcB),
  .srcAIsZero(srcAIsZero),
  .result    (result),
  .carryFlag (carryFlag),
  .statusWord(statusWord)
);

// File: tb/carry_addsub_test.sv
`timescale 1ns/1ps
module carry_addsub_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        opValid = 1'b0;
  logic [1:0]  opSel = 2'b00;
  logic [31:0] srcA = '0;
  logic [31:0] srcB = '0;
  logic        srcAIsZero = 1'b0;
  logic [31:0] result;
  logic        carryFlag;
  logic [31:0] statusWord;

  int  checkCount = 0;
  int  failCount  = 0;
  bit  finished   = 1'b0;
  logic modelCarry = 1'b0;

  always #4 clk = ~clk;

  carry_addsub uut (
    .clk       (clk),
    .rstN      (rstN),
    .opValid   (opValid),
    .opSel     (opSel),
    .srcA      (srcA),
    .srcB      (srcB),
    .srcAIsZero(srcAIsZero),
    .result    (result),
    .carryFlag (carryFlag),
    .statusWord(statusWord)
  );

  function automatic logic [32:0] model(input logic [1:0] op, input logic [31:0] a,
                                        input logic [31:0] b, input logic z, input logic ca);
    logic [31:0] aa;
    aa = z ? 32'h0 : a;
    case (op)
      2'b00:   return {1'b0, a} + {1'b0, b};
      2'b01:   return {1'b0, aa} + {1'b0, b} + {32'h0, ca};
      2'b10:   return {1'b0, a} + {1'b0, ~b} + 33'd1;
      default: return {1'b0, ~aa} + {1'b0, b} + {32'h0, ca};
    endcase
  endfunction

  function automatic string opTag(input logic [1:0] op);
    case (op)
      2'b00:   return "R2";
      2'b01:   return "R3";
      2'b10:   return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checkCount++;
    if (!ok) begin
      failCount++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic checkStatus();
    check(statusWord == {29'h0, carryFlag, 2'b00}, "R7", 64'(statusWord), 64'({29'h0, carryFlag, 2'b00}));
  endtask

  // One operation: drive on falling edge, sample after the next rising edge.
  task automatic doOp(input logic [1:0] op, input logic [31:0] a, input logic [31:0] b,
                      input logic z, input string extraTag);
    logic [32:0] exp;
    @(negedge clk);
    opValid = 1'b1; opSel = op; srcA = a; srcB = b; srcAIsZero = z;
    exp = model(op, a, b, z, modelCarry);
    @(posedge clk);
    #2;
    check({carryFlag, result} == exp, {opTag(op), extraTag}, 64'({carryFlag, result}), 64'(exp));
    if (op == 2'b10)
      check(carryFlag == (a >= b), "R4 no-borrow", 64'(carryFlag), 64'(a >= b));
    checkStatus();
    modelCarry = exp[32];
  endtask

  task automatic idle(input int cycles);
    logic [31:0] heldRes;
    logic        heldCa;
    heldRes = result;
    heldCa  = carryFlag;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      opValid = 1'b0; opSel = 2'(i); srcA = $urandom; srcB = $urandom; srcAIsZero = 1'(i);
      @(posedge clk);
      #2;
      check(result == heldRes && carryFlag == heldCa, "R8 hold",
            64'({carryFlag, result}), 64'({heldCa, heldRes}));
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checkCount++;
      failCount++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", checkCount - failCount, checkCount);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_c0de));
    repeat (3) @(posedge clk);
    #2;
    check(result == 0 && carryFlag == 0 && statusWord == 0, "R1 reset",
          64'({statusWord, carryFlag, result}), 64'(0));
    @(negedge clk);
    rstN = 1'b1;

    // Carry set by wrap, then an extended add of zero+zero picks it up (R9)
    doOp(2'b00, 32'hFFFF_FFFE, 32'h0000_000B, 1'b0, " wrap");
    doOp(2'b01, 32'h1234_5678, 32'h0, 1'b1, " R6 zero-A R9 chained");
    check(result == 32'h1 && carryFlag == 1'b0, "R9 high word", 64'({carryFlag, result}), 64'(1));

    // Borrow clears the flag, then subtract-from with zero A, B=2 gives 1
    doOp(2'b10, 32'h1, 32'h3, 1'b0, " borrow");
    check(result == 32'hFFFF_FFFE && carryFlag == 1'b0, "R4 borrow value",
          64'({carryFlag, result}), 64'({1'b0, 32'hFFFF_FFFE}));
    doOp(2'b11, 32'hDEAD_BEEF, 32'h2, 1'b1, " R6 zero-A R9 chained");
    check(result == 32'h1, "R5 high word", 64'(result), 64'(1));

    // Edges
    doOp(2'b10, 32'h55, 32'h55, 1'b0, " equal");
    doOp(2'b10, 32'h0, 32'h1, 1'b0, " zero minus one");
    doOp(2'b00, 32'hFFFF_FFFF, 32'h1, 1'b0, " exact wrap");
    doOp(2'b01, 32'hFFFF_FFFF, 32'h0, 1'b0, " ext wrap");
    doOp(2'b01, 32'h0000_0010, 32'h0000_0020, 1'b0, " R6 A used");
    // R6: zero flag ignored in carrying forms
    doOp(2'b00, 32'h7000_0000, 32'h9000_0000, 1'b1, " R6 ignored");
    doOp(2'b10, 32'h0000_0100, 32'h0000_0001, 1'b1, " R6 ignored");
    doOp(2'b11, 32'h0000_0005, 32'h0000_0009, 1'b0, " nonzero A");
    idle(4);

    for (int n = 0; n < 400; n++) begin
      logic [31:0] ra;
      logic [31:0] rb;
      ra = $urandom;
      rb = $urandom;
      if (n % 7 == 0) ra = 32'hFFFF_FFFF;
      if (n % 11 == 0) rb = ra;
      doOp(2'($urandom), ra, rb, 1'($urandom), " random");
      if (n % 50 == 49) idle(2);
    end

    finished = 1'b1;
    $display("%0d/%0d checks passed", checkCount - failCount, checkCount);
    $finish;
  end

endmodule